// File: doc/BRIEF.md
# PDM Microphone Receiver

This block connects one or two pulse-density microphones that share a single data wire to a PCM stream. It drives the microphone bit clock by dividing the system clock. It sorts the incoming bits into a left and a right stream by the clock phase in which each bit is presented. Each stream is decimated by a fourth-order cascaded integrator-comb filter. The result then passes a first-order DC-blocking high-pass and a Q23 gain multiply, and is saturated to signed 24 bits.

All settings are static inputs. Oversampling ratio and edge polarity are captured when the block is enabled. Channel mode and gain act directly. Each output transfer carries a left word and a right word on a valid/ready handshake. One output sample is produced per OSR pairs of microphone bits.

Top module: `pdm_rx`

## Requirements
- R1: While `enable` is low, or after reset, `pdm_clk` is low and `out_valid` is low. The one-cycle effect of `enable` going low is covered by R11.
- R2: While enabled, `pdm_clk` toggles once every `HALF_DIV` system clock cycles and starts low.
- R3: `osr_sel` selects the number of bit pairs per output sample: code 0 gives 64, code 1 gives 128, code 2 gives 256, and code 3 behaves as code 2. With `out_ready` high, consecutive transfers are OSR*2*`HALF_DIV` cycles apart.
- R4: With `lr_pol`=0, the bit presented while `pdm_clk` is high belongs to the left channel and is captured at the falling edge. The bit presented while `pdm_clk` is low belongs to the right channel and is captured at the rising edge. With `lr_pol`=1 the two channels are swapped.
- R5: `ch_mode` 0 outputs the left channel in `out_left` with `out_right` zero. `ch_mode` 1 outputs the right channel in `out_left` with `out_right` zero. Codes 2 and 3 output both channels, left in `out_left` and right in `out_right`.
- R6: A bit of 1 counts as +1 and a bit of 0 as -1. The decimator uses four cascaded integrators, each updated from the previous stage's old value. Every OSR-th input, four unit-delay combs run on the last integrator. Their result is shifted arithmetically right by 4*log2(OSR)-23, so full scale is about ±2^23.
- R7: The DC stage computes y = x - x_prev + y_prev - (y_prev >>> 10). Its state clears on enable.
- R8: `gain` is unsigned Q23, with 0x800000 as unity. The output is (y*gain + 2^22) >>> 23, saturated to the range [-0x800000, 0x7FFFFF].
- R9: Oversampling code and polarity are taken while the block is disabled. Changes made while it is enabled have no effect until `enable` falls and rises again. All filter state starts from zero at each enable.
- R10: A pending output holds its data and `out_valid` until accepted. A newer sample that arrives before acceptance replaces the pending one.
- R11: One cycle after `enable` is seen low, `out_valid` and `pdm_clk` are low, even if a sample was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low clears all state |
| osr_sel | input | 2 | Oversampling code (64/128/256) |
| lr_pol | input | 1 | Swaps which clock phase carries the left channel |
| ch_mode | input | 2 | Left only, right only, or stereo |
| gain | input | GAIN_W | Unsigned Q23 gain |
| pdm_clk | output | 1 | Microphone bit clock |
| pdm_dat | input | 1 | Shared microphone data line |
| out_valid | output | 1 | Output sample pending |
| out_ready | input | 1 | Consumer accepts the sample |
| out_left | output | 24 | Left (or selected mono) PCM word |
| out_right | output | 24 | Right PCM word, zero in mono modes |

## Verification
The two functions that can meet in one cycle are a newly finished sample and a stalled transfer still holding the older word. The bench holds `out_ready` low from enable until two and a half sample periods have passed, so a second sample lands on the pending one. Its reference model then drops the first expected sample and requires the word accepted at release to be the second. A related collision, a disable arriving while a sample is pending, is provoked with `out_ready` held low. It is judged by `out_valid` and `pdm_clk` being low one cycle later.

// File: rtl/pdm_rx_pkg.sv
// Package: shared widths, channel-mode encoding and oversampling helpers
// for the PDM receiver. Assumes the oversampling code is 2 bits wide.
package pdm_rx_pkg;

    localparam int PCM_W = 24;

    typedef enum logic [1:0] {
        MODE_LEFT   = 2'd0,
        MODE_RIGHT  = 2'd1,
        MODE_STEREO = 2'd2,
        MODE_ALT    = 2'd3
    } ch_mode_e;

    // Folds the unused code 3 onto the largest ratio.
    function automatic logic [1:0] fold_osr(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    // log2 of the oversampling ratio for a folded code.
    function automatic int unsigned osr_log2(input logic [1:0] code);
        return 6 + int'(code);
    endfunction

endpackage

// File: rtl/pdm_clkgen.sv
// Module: bit-clock divider and phase capture. Toggles pdm_clk every
// HALF_DIV cycles. Samples the data line in the last cycle of each phase.
// Emits one tick per pair with the high-phase and low-phase bits.
// Assumes HALF_DIV >= 2 so the data line settles between edges.
module pdm_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pdm_dat,
    output logic pdm_clk,
    output logic tick,
    output logic hi_bit,
    output logic lo_bit
);
    localparam int CNT_W = $clog2(HALF_DIV + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic             clk_q;
    logic             lo_hold;

    // Phase counter, clock toggle, and capture at each phase end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt     <= '0;
            clk_q   <= 1'b0;
            lo_hold <= 1'b0;
            tick    <= 1'b0;
            hi_bit  <= 1'b0;
            lo_bit  <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (cnt == LAST) begin
                cnt   <= '0;
                clk_q <= ~clk_q;
                if (!clk_q) begin
                    lo_hold <= pdm_dat;
                end else begin
                    hi_bit <= pdm_dat;
                    lo_bit <= lo_hold;
                    tick   <= 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign pdm_clk = clk_q;

    initial begin
        assert (HALF_DIV >= 2) else $error("HALF_DIV must be at least 2");
    end

    assert_clk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clk_q);

    assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !$past(clr) && (clk_q != $past(clk_q))) |-> ($past(cnt) == LAST));

endmodule

// File: rtl/pdm_cic.sv
// Module: one channel of the CIC decimator. The integrator chain runs
// on every pair tick. The combs run on dec_stb, which the parent raises
// in the cycle after every OSR-th tick. The result is scaled so full
// scale is about +/-2^(OUT_W-2). Assumes ACC_W holds ORDER*8+2 bits.
module pdm_cic #(
    parameter int ORDER = 4,
    parameter int ACC_W = 34,
    parameter int OUT_W = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    tick,
    input  logic                    bit_in,
    input  logic                    dec_stb,
    input  logic [1:0]              osr_code,
    output logic                    out_stb,
    output logic signed [OUT_W-1:0] out_val
);
    import pdm_rx_pkg::*;

    logic signed [ACC_W-1:0] integ [ORDER];
    logic signed [ACC_W-1:0] dly   [ORDER];
    logic signed [ACC_W-1:0] comb  [ORDER];
    logic signed [ACC_W-1:0] scaled;
    logic [5:0]              shamt;

    // Integrator chain, each stage adding the old value of the one before.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < ORDER; k++) integ[k] <= '0;
        end else if (tick) begin
            integ[0] <= integ[0] + (bit_in ? ACC_W'(1) : -ACC_W'(1));
            for (int k = 1; k < ORDER; k++) integ[k] <= integ[k] + integ[k-1];
        end
    end

    // Comb differences against the previous decimated values.
    always_comb begin
        comb[0] = integ[ORDER-1] - dly[0];
        for (int k = 1; k < ORDER; k++) comb[k] = comb[k-1] - dly[k];
    end

    assign shamt  = 6'(ORDER * osr_log2(osr_code) - (OUT_W - 2));
    assign scaled = comb[ORDER-1] >>> shamt;

    // Comb delay update and scaled output register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < ORDER; k++) dly[k] <= '0;
            out_val <= '0;
            out_stb <= 1'b0;
        end else begin
            out_stb <= dec_stb;
            if (dec_stb) begin
                dly[0] <= integ[ORDER-1];
                for (int k = 1; k < ORDER; k++) dly[k] <= comb[k-1];
                out_val <= scaled[OUT_W-1:0];
            end
        end
    end

    assert_strobe_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stb |-> !tick);

endmodule

// File: rtl/pdm_post.sv
// Module: DC-blocking high-pass followed by Q23 gain with round-half-up
// and saturation to PCM_W bits. Two register stages, each led by a strobe.
// Assumes the input stays within +/-2^(IN_W-1).
module pdm_post #(
    parameter int IN_W     = 25,
    parameter int PCM_W    = 24,
    parameter int GAIN_W   = 28,
    parameter int DC_SHIFT = 10,
    parameter int DC_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    in_stb,
    input  logic signed [IN_W-1:0]  in_val,
    input  logic [GAIN_W-1:0]       gain,
    output logic                    out_stb,
    output logic signed [PCM_W-1:0] out_val
);
    localparam int FRAC = 23;
    localparam int PW   = DC_W + GAIN_W + 1;
    localparam logic signed [PW-1:0] ROUND = PW'(1) <<< (FRAC - 1);
    localparam logic signed [PW-1:0] MAXV  = PW'((1 << (PCM_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV  = -(PW'(1) <<< (PCM_W - 1));
    localparam logic [GAIN_W-1:0]    UNITY = GAIN_W'(1) << FRAC;

    logic signed [DC_W-1:0] x_ext, x_prev, y;
    logic signed [PW-1:0]   prod, rnd;
    logic                   dc_stb;

    assign x_ext = DC_W'(in_val);

    // First-order DC removal with the coefficient 1 - 2^-DC_SHIFT.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            x_prev <= '0;
            y      <= '0;
            dc_stb <= 1'b0;
        end else begin
            dc_stb <= in_stb;
            if (in_stb) begin
                x_prev <= x_ext;
                y      <= x_ext - x_prev + y - (y >>> DC_SHIFT);
            end
        end
    end

    assign prod = PW'(y) * $signed({1'b0, gain});
    assign rnd  = (prod + ROUND) >>> FRAC;

    // Gain stage with saturation to the output range.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            out_val <= '0;
            out_stb <= 1'b0;
        end else begin
            out_stb <= dc_stb;
            if (dc_stb) begin
                if (rnd > MAXV)      out_val <= MAXV[PCM_W-1:0];
                else if (rnd < MINV) out_val <= MINV[PCM_W-1:0];
                else                 out_val <= rnd[PCM_W-1:0];
            end
        end
    end

    assert_unity_gain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_stb && !clr && gain == UNITY && y <= DC_W'(MAXV) && y >= DC_W'(MINV))
        |=> (out_val == $past(y[PCM_W-1:0])));

endmodule

// File: rtl/pdm_rx.sv
// Module: PDM microphone receiver top. Latches oversampling code and
// polarity while disabled. Splits the pair bits into left and right and
// runs one decimator and post stage per channel. Presents the result on
// a valid/ready output. A new sample replaces an unaccepted one.
// Assumes static configuration while enabled.
module pdm_rx #(
    parameter int HALF_DIV  = 2,
    parameter int GAIN_W    = 28,
    parameter int DC_SHIFT  = 10,
    parameter int CIC_ORDER = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        osr_sel,
    input  logic              lr_pol,
    input  logic [1:0]        ch_mode,
    input  logic [GAIN_W-1:0] gain,
    output logic              pdm_clk,
    input  logic              pdm_dat,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [23:0]       out_left,
    output logic [23:0]       out_right
);
    import pdm_rx_pkg::*;

    localparam int PRE_W = PCM_W + 1;
    localparam int ACC_W = CIC_ORDER * 8 + 2;
    localparam int DC_W  = PCM_W + 8;
    localparam int NCH   = 2;

    logic       run_q;
    logic [1:0] osr_q;
    logic       pol_q;
    logic       clr;
    logic       tick, hi_bit, lo_bit;
    logic [7:0] dcnt, dec_lim;
    logic       dec_stb;
    logic [NCH-1:0]          ch_bit;
    logic [NCH-1:0]          cic_stb, post_stb;
    logic signed [PRE_W-1:0] cic_val  [NCH];
    logic signed [PCM_W-1:0] post_val [NCH];

    assign clr = !enable;

    // Configuration capture, open only while the block is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            osr_q <= 2'd0;
            pol_q <= 1'b0;
        end else begin
            run_q <= enable;
            if (!run_q) begin
                osr_q <= fold_osr(osr_sel);
                pol_q <= lr_pol;
            end
        end
    end

    pdm_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pdm_dat(pdm_dat),
        .pdm_clk(pdm_clk), .tick(tick), .hi_bit(hi_bit), .lo_bit(lo_bit)
    );

    assign dec_lim = 8'((9'd64 << osr_q) - 9'd1);

    // Decimation counter shared by both channels.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dcnt    <= '0;
            dec_stb <= 1'b0;
        end else begin
            dec_stb <= 1'b0;
            if (tick) begin
                if (dcnt == dec_lim) begin
                    dcnt    <= '0;
                    dec_stb <= 1'b1;
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end
        end
    end

    assign ch_bit[0] = pol_q ? lo_bit : hi_bit;
    assign ch_bit[1] = pol_q ? hi_bit : lo_bit;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pdm_cic #(.ORDER(CIC_ORDER), .ACC_W(ACC_W), .OUT_W(PRE_W)) u_cic (
            .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
            .bit_in(ch_bit[c]), .dec_stb(dec_stb), .osr_code(osr_q),
            .out_stb(cic_stb[c]), .out_val(cic_val[c])
        );
        pdm_post #(.IN_W(PRE_W), .PCM_W(PCM_W), .GAIN_W(GAIN_W),
                   .DC_SHIFT(DC_SHIFT), .DC_W(DC_W)) u_post (
            .clk(clk), .rst_n(rst_n), .clr(clr), .in_stb(cic_stb[c]),
            .in_val(cic_val[c]), .gain(gain),
            .out_stb(post_stb[c]), .out_val(post_val[c])
        );
    end

    // Output register: load by channel mode, drop on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else if (post_stb[0]) begin
            out_valid <= 1'b1;
            case (ch_mode_e'(ch_mode))
                MODE_LEFT: begin
                    out_left  <= post_val[0];
                    out_right <= '0;
                end
                MODE_RIGHT: begin
                    out_left  <= post_val[1];
                    out_right <= '0;
                end
                default: begin
                    out_left  <= post_val[0];
                    out_right <= post_val[1];
                end
            endcase
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assert_idle_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!out_valid && !pdm_clk));

    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && enable && !post_stb[0])
        |=> (out_valid && $stable(out_left) && $stable(out_right)));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && enable) |=> ($stable(osr_q) && $stable(pol_q)));

    assert_mono_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (post_stb[0] && enable && (ch_mode == 2'd0 || ch_mode == 2'd1))
        |=> (out_right == '0));

    assert_lanes_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        post_stb[0] == post_stb[1]);

endmodule

// File: tb/test_pdm_rx.sv
// Bench: drives the shared data line from two per-channel bit patterns,
// following the bit clock the design produces. A behavioural model
// (integers and a queue) predicts every output word. Each clock the
// bench compares handshakes against the queue.
module test_pdm_rx;
    localparam int HALF_DIV = 2;
    localparam int GAIN_W   = 28;
    localparam int WDOG     = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [1:0] osr_sel = 2'd0;
    logic lr_pol = 1'b0;
    logic [1:0] ch_mode = 2'd2;
    logic [GAIN_W-1:0] gain = 28'h0800000;
    logic pdm_clk, pdm_dat, out_valid;
    logic out_ready = 1'b1;
    logic [23:0] out_left, out_right;

    int n_cmp = 0, n_bad = 0, cycle = 0;
    logic [47:0] expq [$];
    string cur_req = "R1";
    int pat_l = 0, pat_r = 0, cur_pol = 0;
    int hs_n = 0, hs_prev = 0, hs_last = 0;
    int half_len = 0, half_bad = 0, half_seen = 0;

    pdm_rx #(.HALF_DIV(HALF_DIV), .GAIN_W(GAIN_W)) i_pdm_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .osr_sel(osr_sel),
        .lr_pol(lr_pol), .ch_mode(ch_mode), .gain(gain),
        .pdm_clk(pdm_clk), .pdm_dat(pdm_dat), .out_valid(out_valid),
        .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    function automatic bit pat_bit(int pat, int p);
        case (pat)
            0: return 1'b0;
            1: return 1'b1;
            2: return 1'(((p * 1103515245 + 12345) >>> 16) & 1);
            default: return 1'(((p * 37) % 7) < 5);
        endcase
    endfunction

    function automatic bit hi_stream(int p);
        return (cur_pol != 0) ? pat_bit(pat_r, p) : pat_bit(pat_l, p);
    endfunction
    function automatic bit lo_stream(int p);
        return (cur_pol != 0) ? pat_bit(pat_l, p) : pat_bit(pat_r, p);
    endfunction

    // Data-line driver: presents the next bit after each clock edge.
    int hi_i = 0, lo_i = 1;
    logic prev_clk = 1'b0;
    always @(negedge clk) begin
        if (!enable) begin
            prev_clk = 1'b0; hi_i = 0; lo_i = 1; half_len = 0;
            pdm_dat = lo_stream(0);
        end else begin
            half_len++;
            if (pdm_clk != prev_clk) begin
                if (half_seen > 0 && half_len != HALF_DIV) half_bad++;
                half_seen++;
                half_len = 0;
                prev_clk = pdm_clk;
                if (pdm_clk) begin pdm_dat = hi_stream(hi_i); hi_i++; end
                else         begin pdm_dat = lo_stream(lo_i); lo_i++; end
            end
        end
    end

    // Monitor: compare every accepted word with the model queue.
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            n_cmp++;
            hs_prev = hs_last; hs_last = cycle; hs_n++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL %s: unexpected word %h_%h, expected none", cur_req, out_left, out_right);
            end else begin
                if ({out_left, out_right} !== expq[0]) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", cur_req, {out_left, out_right}, expq[0]);
                end
                void'(expq.pop_front());
            end
        end
    end

    function automatic longint sat24(longint v);
        if (v > 64'sd8388607) return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    // Reference model (R6, R7, R8, R5): fills the queue for n samples.
    task automatic build_expected(int n, int code, int mode, longint g);
        longint ig [2][4];
        longint dl [2][4];
        longint xp [2];
        longint yp [2];
        longint res [2];
        int lg = (code == 3) ? 8 : 6 + code;
        int r = 1 << lg;
        int sh = 4 * lg - 23;
        for (int c = 0; c < 2; c++) begin
            xp[c] = 0; yp[c] = 0;
            for (int k = 0; k < 4; k++) begin ig[c][k] = 0; dl[c][k] = 0; end
        end
        for (int p = 0; p < n * r; p++) begin
            for (int c = 0; c < 2; c++) begin
                longint x = pat_bit(c == 0 ? pat_l : pat_r, p) ? 1 : -1;
                for (int k = 3; k > 0; k--) ig[c][k] += ig[c][k-1];
                ig[c][0] += x;
            end
            if ((p + 1) % r == 0) begin
                for (int c = 0; c < 2; c++) begin
                    longint v = ig[c][3];
                    longint s, y;
                    for (int k = 0; k < 4; k++) begin
                        longint t = v - dl[c][k];
                        dl[c][k] = v;
                        v = t;
                    end
                    s = v >>> sh;
                    y = s - xp[c] + yp[c] - (yp[c] >>> 10);
                    xp[c] = s; yp[c] = y;
                    res[c] = sat24((y * g + 64'sd4194304) >>> 23);
                end
                if (mode == 0)      expq.push_back({24'(res[0]), 24'd0});
                else if (mode == 1) expq.push_back({24'(res[1]), 24'd0});
                else                expq.push_back({24'(res[0]), 24'(res[1])});
            end
        end
    endtask

    task automatic check(bit ok, string req, string what, longint act, longint exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic setup(int code, int pol, int mode, longint g, int pl, int pr, int n, string req);
        @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        cur_req = req; pat_l = pl; pat_r = pr; cur_pol = pol;
        osr_sel = 2'(code); lr_pol = 1'(pol); ch_mode = 2'(mode); gain = GAIN_W'(g);
        expq.delete();
        build_expected(n, code, mode, g);
        hs_n = 0; half_seen = 0; half_bad = 0;
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic drain(int code);
        int lim = 40 * (64 << ((code == 3) ? 2 : code)) * 2 * HALF_DIV;
        int t = 0;
        while (expq.size() != 0 && t < lim) begin @(negedge clk); t++; end
        check(expq.size() == 0, cur_req, "words left undelivered", expq.size(), 0);
        repeat (4) @(negedge clk);
        enable = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(!out_valid && !pdm_clk, "R1", "reset outputs", {out_valid, pdm_clk}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        #2;
        check(!out_valid && !pdm_clk, "R1", "idle outputs", {out_valid, pdm_clk}, 0);

        // R6 R7 R2 R3: OSR 64, stereo, unity gain, two irregular patterns.
        setup(0, 0, 2, 64'h800000, 2, 3, 8, "R6 R7 R3");
        drain(0);
        check(half_bad == 0 && half_seen > 10, "R2", "pdm_clk half periods off", half_bad, 0);
        check(hs_last - hs_prev == 64 * 2 * HALF_DIV, "R3", "sample interval code0",
              hs_last - hs_prev, 64 * 2 * HALF_DIV);

        // R4: swapped polarity, left all ones, OSR 128, gain one half.
        setup(1, 1, 2, 64'h400000, 1, 3, 6, "R4");
        drain(1);
        check(hs_last - hs_prev == 128 * 2 * HALF_DIV, "R3", "sample interval code1",
              hs_last - hs_prev, 128 * 2 * HALF_DIV);

        // R5: left only at OSR 256.
        setup(2, 0, 0, 64'h800000, 3, 2, 5, "R5");
        drain(2);

        // R5 R3: right only with code 3 folding to 256.
        setup(3, 0, 1, 64'h800000, 2, 3, 5, "R5 R3");
        drain(3);
        check(hs_last - hs_prev == 256 * 2 * HALF_DIV, "R3", "sample interval code3",
              hs_last - hs_prev, 256 * 2 * HALF_DIV);

        // R8: high gain drives both saturation limits.
        setup(0, 0, 2, 64'hFFFFFFF, 1, 0, 6, "R8");
        drain(0);

        // R9: oversampling and polarity changed while running are ignored.
        setup(2, 0, 2, 64'h800000, 1, 2, 4, "R9");
        repeat (100) @(negedge clk);
        osr_sel = 2'd0; lr_pol = 1'b1;
        drain(2);
        check(hs_last - hs_prev == 256 * 2 * HALF_DIV, "R9", "interval after live change",
              hs_last - hs_prev, 256 * 2 * HALF_DIV);

        // R10: stall across two sample completions; the newer word wins.
        out_ready = 1'b0;
        setup(0, 0, 2, 64'h800000, 3, 2, 6, "R10");
        repeat (640) @(negedge clk);
        #2;
        check(out_valid, "R10", "pending word lost during stall", out_valid, 1);
        void'(expq.pop_front());
        @(negedge clk);
        out_ready = 1'b1;
        drain(0);

        // R11 R1: disable while a word is pending.
        out_ready = 1'b0;
        setup(0, 0, 2, 64'h800000, 2, 2, 1, "R11");
        repeat (300) @(negedge clk);
        #2;
        check(out_valid, "R11", "word pending before disable", out_valid, 1);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        #2;
        check(!out_valid && !pdm_clk, "R11", "outputs one cycle after disable",
              {out_valid, pdm_clk}, 0);
        expq.delete();
        repeat (20) @(negedge clk);
        #2;
        check(!out_valid && !pdm_clk, "R1", "outputs while disabled", {out_valid, pdm_clk}, 0);
        out_ready = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycle >= WDOG);
        n_bad++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycle);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule